// File: doc/BRIEF.md
# Expired Unused Prefetch Monitor

This block measures how useful prefetching is in a cache whose lines lose their contents once a retention time has passed. It keeps one flag per cache line that marks the line as holding prefetched data that no demand access has touched yet. Event pulses from the cache (line fills, demand hits, expirations, evictions) update these flags. A line that expires while its flag is still set is counted as an expired unused prefetch.

Alongside that count, the block counts prefetch fills and requests sent to the miss-status holding registers (MSHR). Counting runs over a sampling interval measured in retired instructions, with a default of ten million. When an interval ends, the three totals are latched into output registers, a one-cycle done strobe is raised, and the live counters start again from zero. Tuning logic elsewhere reads the totals at the strobe to choose a retention time and a prefetch distance.

Top module: `expired_pf_monitor`

## Requirements
- R1: A fill with `fill_pf_i`=1 sets the prefetch flag of `fill_line_i`, and a fill with `fill_pf_i`=0 clears it. A fill takes priority over any hit, expiry or eviction to the same line in the same cycle.
- R2: A demand hit clears the flag of its line, so a later expiry of that line is not counted.
- R3: An expiry of a line whose flag is set increments the expired-unused count. An expiry is not counted if a demand hit to the same line arrives in the same cycle.
- R4: An eviction clears the flag of its line and never increments the expired-unused count.
- R5: An expiry of a line whose flag is clear is not counted.
- R6: Each fill with `fill_pf_i`=1 increments the prefetch count.
- R7: Each cycle with `mshr_req_i`=1 increments the MSHR request count.
- R8: Every count saturates at 2^CNT_W-1 and does not wrap.
- R9: The interval ends in the cycle of the INTERVAL_LEN-th `retire_i` pulse since the previous end or since reset. `interval_done_o` is high for exactly the following cycle.
- R10: Events in the ending cycle are included in the latched totals. The live counts restart from zero in the next cycle.
- R11: After reset all outputs are zero and no line carries a prefetch flag.
- R12: The three total outputs change only in the cycle in which `interval_done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One instruction retired this cycle |
| mshr_req_i | input | 1 | One request sent to the MSHRs this cycle |
| fill_valid_i | input | 1 | Line fill this cycle |
| fill_pf_i | input | 1 | The fill was caused by a prefetch |
| fill_line_i | input | LINE_W | Line index of the fill |
| hit_valid_i | input | 1 | Demand hit this cycle |
| hit_line_i | input | LINE_W | Line index of the demand hit |
| expire_valid_i | input | 1 | Retention expiry this cycle |
| expire_line_i | input | LINE_W | Line index of the expiry |
| evict_valid_i | input | 1 | Eviction this cycle |
| evict_line_i | input | LINE_W | Line index of the eviction |
| interval_done_o | output | 1 | Totals updated; high for one cycle |
| mshr_total_o | output | CNT_W | MSHR requests in the last interval |
| pf_total_o | output | CNT_W | Prefetch fills in the last interval |
| exp_unused_o | output | CNT_W | Expired unused prefetches in the last interval |

## Verification
Some properties are checked on every cycle:
- the flag update after a prefetch fill and after a demand hit;
- the increment of the live expired-unused count on an unused expiry;
- saturation holding at the top value;
- the live counters being zero right after an interval ends;
- the done strobe lasting one cycle;
- the totals holding between strobes.

Other behaviours show only at the totals, so the bench's scenarios must expose them:
- same-cycle conflicts on one line (expiry with a hit, fill with an expiry);
- eviction leaving the count untouched;
- events in the boundary cycle being included;
- the exact interval length.

// File: rtl/epm_pkg.sv
package epm_pkg;
  typedef enum int unsigned {
    CNT_MSHR = 0,
    CNT_PF   = 1,
    CNT_EXP  = 2
  } cnt_idx_e;
  localparam int unsigned NUM_CNT = 3;
endpackage

// File: rtl/epm_line_flags.sv
module epm_line_flags #(
  parameter int unsigned NUM_LINES = 512,
  parameter int unsigned LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fill_valid_i,
  input  logic                 fill_pf_i,
  input  logic [LINE_W-1:0]    fill_line_i,
  input  logic                 hit_valid_i,
  input  logic [LINE_W-1:0]    hit_line_i,
  input  logic                 expire_valid_i,
  input  logic [LINE_W-1:0]    expire_line_i,
  input  logic                 evict_valid_i,
  input  logic [LINE_W-1:0]    evict_line_i,
  output logic [NUM_LINES-1:0] flags_o,
  output logic                 exp_unused_o
);
  logic [NUM_LINES-1:0] flags_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic fill_here, clr_here;
    assign fill_here = fill_valid_i && (fill_line_i == LINE_W'(i));
    assign clr_here  = (hit_valid_i    && (hit_line_i    == LINE_W'(i))) ||
                       (expire_valid_i && (expire_line_i == LINE_W'(i))) ||
                       (evict_valid_i  && (evict_line_i  == LINE_W'(i)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_q[i] <= 1'b0;
      else if (fill_here) flags_q[i] <= fill_pf_i;
      else if (clr_here)  flags_q[i] <= 1'b0;
    end
  end

  // same-cycle demand hit counts as a use
  assign exp_unused_o = expire_valid_i && flags_q[expire_line_i] &&
                        !(hit_valid_i && (hit_line_i == expire_line_i));
  assign flags_o = flags_q;
endmodule

// File: rtl/epm_sat_cnt.sv
module epm_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] cnt_q;

  assign nxt_o = (inc_i && (cnt_q != '1)) ? cnt_q + W'(1) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/epm_interval.sv
module epm_interval #(
  parameter int unsigned LEN = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic retire_i,
  output logic end_o
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  assign end_o = retire_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (end_o)    cnt_q <= '0;
    else if (retire_i) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/expired_pf_monitor.sv
module expired_pf_monitor
  import epm_pkg::*;
#(
  parameter int unsigned NUM_LINES    = 512,
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned INTERVAL_LEN = 10_000_000,
  parameter int unsigned LINE_W       = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retire_i,
  input  logic              mshr_req_i,
  input  logic              fill_valid_i,
  input  logic              fill_pf_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              hit_valid_i,
  input  logic [LINE_W-1:0] hit_line_i,
  input  logic              expire_valid_i,
  input  logic [LINE_W-1:0] expire_line_i,
  input  logic              evict_valid_i,
  input  logic [LINE_W-1:0] evict_line_i,
  output logic              interval_done_o,
  output logic [CNT_W-1:0]  mshr_total_o,
  output logic [CNT_W-1:0]  pf_total_o,
  output logic [CNT_W-1:0]  exp_unused_o
);
  logic [NUM_LINES-1:0]            pf_flags;
  logic                            exp_unused_ev;
  logic                            interval_end;
  logic [NUM_CNT-1:0]              cnt_inc;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_q;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_nxt;
  logic [NUM_CNT-1:0][CNT_W-1:0]   total_q;
  logic                            done_q;

  epm_line_flags #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_flags (
    .clk_i, .rst_ni,
    .fill_valid_i, .fill_pf_i, .fill_line_i,
    .hit_valid_i, .hit_line_i,
    .expire_valid_i, .expire_line_i,
    .evict_valid_i, .evict_line_i,
    .flags_o      (pf_flags),
    .exp_unused_o (exp_unused_ev)
  );

  epm_interval #(.LEN(INTERVAL_LEN)) u_interval (
    .clk_i, .rst_ni, .retire_i,
    .end_o (interval_end)
  );

  assign cnt_inc[CNT_MSHR] = mshr_req_i;
  assign cnt_inc[CNT_PF]   = fill_valid_i && fill_pf_i;
  assign cnt_inc[CNT_EXP]  = exp_unused_ev;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    epm_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .inc_i (cnt_inc[k]),
      .clr_i (interval_end),
      .cnt_o (cnt_q[k]),
      .nxt_o (cnt_nxt[k])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           total_q[k] <= '0;
      else if (interval_end) total_q[k] <= cnt_nxt[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= interval_end;
  end

  assign interval_done_o = done_q;
  assign mshr_total_o    = total_q[CNT_MSHR];
  assign pf_total_o      = total_q[CNT_PF];
  assign exp_unused_o    = total_q[CNT_EXP];
endmodule

// File: rtl/epm_checker.sv
module epm_checker #(
  parameter int unsigned NUM_LINES = 512,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned LINE_W    = $clog2(NUM_LINES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 fill_valid_i,
  input logic                 fill_pf_i,
  input logic [LINE_W-1:0]    fill_line_i,
  input logic                 hit_valid_i,
  input logic [LINE_W-1:0]    hit_line_i,
  input logic                 expire_valid_i,
  input logic [LINE_W-1:0]    expire_line_i,
  input logic [NUM_LINES-1:0] pf_flags,
  input logic                 interval_end,
  input logic [2:0][CNT_W-1:0] cnt_q,
  input logic                 interval_done_o,
  input logic [CNT_W-1:0]     mshr_total_o,
  input logic [CNT_W-1:0]     pf_total_o,
  input logic [CNT_W-1:0]     exp_unused_o
);
  // R1
  pf_fill_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fill_pf_i) |=> pf_flags[$past(fill_line_i)]);

  // R2
  hit_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_i && !(fill_valid_i && fill_line_i == hit_line_i))
      |=> !pf_flags[$past(hit_line_i)]);

  // R3
  exp_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_valid_i && pf_flags[expire_line_i] &&
     !(hit_valid_i && hit_line_i == expire_line_i) &&
     !interval_end && cnt_q[2] != '1)
      |=> cnt_q[2] == $past(cnt_q[2]) + CNT_W'(1));

  // R8
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!interval_end && cnt_q[0] == '1) |=> cnt_q[0] == '1);

  // R10
  live_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interval_end |=> (cnt_q[0] == '0 && cnt_q[1] == '0 && cnt_q[2] == '0));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interval_done_o |=> !interval_done_o);

  // R12
  totals_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !interval_done_o |-> ($stable(mshr_total_o) && $stable(pf_total_o) &&
                          $stable(exp_unused_o)));
endmodule

bind expired_pf_monitor epm_checker #(
  .NUM_LINES(NUM_LINES), .CNT_W(CNT_W), .LINE_W(LINE_W)
) u_epm_checker (
  .clk_i, .rst_ni,
  .fill_valid_i, .fill_pf_i, .fill_line_i,
  .hit_valid_i, .hit_line_i,
  .expire_valid_i, .expire_line_i,
  .pf_flags, .interval_end, .cnt_q,
  .interval_done_o, .mshr_total_o, .pf_total_o, .exp_unused_o
);

// File: tb/expired_pf_monitor_bench.sv
module expired_pf_monitor_bench;
  localparam int unsigned NL   = 16;
  localparam int unsigned CW   = 5;
  localparam int unsigned LEN  = 40;
  localparam int unsigned LW   = 4;
  localparam int          MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic retire, mshr, fv, fpf, hv, xv, ev;
  logic [LW-1:0] fl, hl, xl, el;
  logic done;
  logic [CW-1:0] o_mshr, o_pf, o_exp;

  expired_pf_monitor #(.NUM_LINES(NL), .CNT_W(CW), .INTERVAL_LEN(LEN)) u_expired_pf_monitor (
    .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .mshr_req_i(mshr),
    .fill_valid_i(fv), .fill_pf_i(fpf), .fill_line_i(fl),
    .hit_valid_i(hv), .hit_line_i(hl),
    .expire_valid_i(xv), .expire_line_i(xl),
    .evict_valid_i(ev), .evict_line_i(el),
    .interval_done_o(done), .mshr_total_o(o_mshr), .pf_total_o(o_pf), .exp_unused_o(o_exp)
  );

  // reference model
  bit m_flag [NL];
  int m_live [3];
  int m_tot  [3];
  int m_icnt;
  bit m_done;
  int compared = 0, mismatched = 0, cycles = 0;
  string tag = "R11";

  function automatic int sat(int v, bit inc);
    return (inc && v < MAXV) ? v + 1 : v;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      bit xu;
      int n [3];
      xu = xv && m_flag[xl] && !(hv && hl == xl);
      n[0] = sat(m_live[0], mshr);
      n[1] = sat(m_live[1], fv && fpf);
      n[2] = sat(m_live[2], xu);
      if (retire && m_icnt == LEN - 1) begin
        for (int k = 0; k < 3; k++) begin m_tot[k] = n[k]; m_live[k] = 0; end
        m_icnt = 0;
        m_done = 1'b1;
      end else begin
        for (int k = 0; k < 3; k++) m_live[k] = n[k];
        if (retire) m_icnt++;
        m_done = 1'b0;
      end
      if (hv) m_flag[hl] = 1'b0;
      if (xv) m_flag[xl] = 1'b0;
      if (ev) m_flag[el] = 1'b0;
      if (fv) m_flag[fl] = fpf;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(tag, "interval_done_o", int'(done), int'(m_done));
    chk(tag, "mshr_total_o", int'(o_mshr), m_tot[0]);
    chk(tag, "pf_total_o", int'(o_pf), m_tot[1]);
    chk(tag, "exp_unused_o", int'(o_exp), m_tot[2]);
  end

  task automatic idle();
    {retire, mshr, fv, fpf, hv, xv, ev} = '0;
    {fl, hl, xl, el} = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic close_interval();
    int left;
    left = LEN - m_icnt;
    for (int i = 0; i < left; i++) begin retire = 1'b1; step(); end
    step();
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL R9 watchdog: got %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) m_flag[i] = 1'b0;
    for (int k = 0; k < 3; k++) begin m_live[k] = 0; m_tot[k] = 0; end
    m_icnt = 0; m_done = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1 R2 R3 R4 R5 R6 R7 directed interval
    tag = "R1";
    fv = 1; fpf = 1; fl = 3; mshr = 1; step();
    fv = 1; fpf = 0; fl = 4; mshr = 1; step();
    fv = 1; fpf = 1; fl = 5; step();
    tag = "R2";
    hv = 1; hl = 5; step();
    tag = "R3";
    xv = 1; xl = 3; step();
    tag = "R5";
    xv = 1; xl = 4; step();
    tag = "R2";
    xv = 1; xl = 5; step();
    tag = "R4";
    fv = 1; fpf = 1; fl = 6; step();
    ev = 1; el = 6; step();
    xv = 1; xl = 6; step();
    tag = "R3";
    fv = 1; fpf = 1; fl = 7; step();
    xv = 1; xl = 7; hv = 1; hl = 7; step();
    tag = "R1";
    fv = 1; fpf = 1; fl = 8; xv = 1; xl = 8; mshr = 1; step();
    xv = 1; xl = 8; step();
    tag = "R10";
    fv = 1; fpf = 1; fl = 9; step();
    // boundary cycle carries events
    for (int i = m_icnt; i < LEN - 1; i++) begin retire = 1; step(); end
    retire = 1; mshr = 1; xv = 1; xl = 9; step();
    step();
    tag = "R3";
    chk("R3", "directed exp_unused_o", int'(o_exp), 3);
    chk("R6", "directed pf_total_o", int'(o_pf), 6);
    chk("R7", "directed mshr_total_o", int'(o_mshr), 4);

    // R10 empty next interval
    tag = "R10";
    close_interval();
    chk("R10", "empty interval exp_unused_o", int'(o_exp), 0);
    chk("R12", "totals hold after strobe", int'(o_mshr), 0);

    // R8 saturation
    tag = "R8";
    for (int i = 0; i < 60; i++) begin
      mshr = 1; fv = 1; fpf = 1; fl = LW'(i % NL);
      retire = (i % 2 == 0); step();
    end
    close_interval();
    chk("R8", "saturated mshr_total_o", int'(o_mshr), MAXV);

    // R9 exact interval length, random traffic
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      retire = ($urandom_range(0, 3) != 0);
      mshr   = ($urandom_range(0, 3) == 0);
      fv = ($urandom_range(0, 2) == 0); fpf = $urandom_range(0, 1); fl = LW'($urandom_range(0, NL-1));
      hv = ($urandom_range(0, 3) == 0); hl = LW'($urandom_range(0, NL-1));
      xv = ($urandom_range(0, 2) == 0); xl = LW'($urandom_range(0, NL-1));
      ev = ($urandom_range(0, 5) == 0); el = LW'($urandom_range(0, NL-1));
      step();
    end
    close_interval();

    // R11 reset clears everything
    tag = "R11";
    rst_n = 1'b0;
    for (int i = 0; i < NL; i++) m_flag[i] = 1'b0;
    for (int k = 0; k < 3; k++) begin m_live[k] = 0; m_tot[k] = 0; end
    m_icnt = 0; m_done = 1'b0;
    step();
    chk("R11", "reset exp_unused_o", int'(o_exp), 0);
    rst_n = 1'b1;
    xv = 1; xl = 3; step();
    close_interval();
    chk("R11", "no flags after reset", int'(o_exp), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule